// File: doc/BRIEF.md
# Double-Precision to Unsigned 32-bit Integer Converter

This unit takes one 64-bit IEEE-754 double-precision operand and returns its value as a 32-bit unsigned integer, one clock cycle after the operand is presented. The output is registered. Alongside the integer it reports two flags for that single conversion. `invalid` means the value cannot be represented. `inexact` means nonzero fraction bits were discarded by rounding.

The rounding mode is taken from one of two 2-bit sources. `rm_global` is a long-lived control setting, and `rm_override` is supplied with a single operation. `rm_sel` picks between them on each conversion.

The range check is made on the rounded value, not on the raw operand. As a result, an operand just below 2^32 can become invalid under one mode and stay valid under another. Negative operands are accepted only when they round to zero. Zeros, subnormals, normals, infinities and NaNs are all handled directly, with no flush of subnormals.

Top module: `dcvt_u32`

## Requirements
- R1: When `rm_sel` is 1 the rounding mode is `rm_override`; when `rm_sel` is 0 it is `rm_global`.
- R2: Mode encoding is 2'b00 nearest with ties to even, 2'b01 toward minus infinity, 2'b10 toward plus infinity, 2'b11 toward zero. An operand that is already an integer in range converts exactly under every mode with both flags clear.
- R3: When the operand has a nonzero fractional part and the conversion is not invalid, `inexact` is 1. Otherwise `inexact` is 0.
- R4: If the rounded magnitude of a positive operand is 2^32 or more, `result` is 32'hFFFF_FFFF and `invalid` is 1. This includes 2^32-0.5 rounded to nearest, while the same operand rounded toward zero gives 32'hFFFF_FFFF with `invalid` 0.
- R5: An operand with all exponent bits set (infinity or NaN, either sign) gives `result` 32'hFFFF_FFFF, `invalid` 1 and `inexact` 0.
- R6: A negative operand whose rounded magnitude is 0, including -0.0, gives `result` 0 and `invalid` 0. `inexact` then follows R3.
- R7: A negative operand whose rounded magnitude is nonzero is invalid.
- R8: `invalid` and `inexact` are never 1 together.
- R9: An operand accepted with `in_valid` high appears on `result`, `invalid` and `inexact` at the next rising edge, with `out_valid` high for that cycle. While `in_valid` is low the outputs hold their values and `out_valid` is 0.
- R10: While `rst_n` is low, `out_valid`, `result`, `invalid` and `inexact` are all 0.
- R11: Subnormal operands are converted by value. A positive subnormal gives 0 with `inexact` under nearest, toward-zero and toward-minus-infinity, and gives 1 under toward-plus-infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present; enables the output registers |
| operand | input | 64 | Double-precision input value |
| rm_global | input | 2 | Rounding mode from the global control setting |
| rm_override | input | 2 | Rounding mode given with this operation |
| rm_sel | input | 1 | 1 selects `rm_override`, 0 selects `rm_global` |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Unsigned integer result |
| invalid | output | 1 | Value not representable; result saturated |
| inexact | output | 1 | Fraction discarded by rounding |

## Verification
The hardest cases to reach are the ones where rounding itself moves a value across a boundary. One is the operand 2^32-0.5, which overflows only after a round-up. The other is a small negative value, which becomes invalid only when the mode pushes its magnitude up to 1. Random doubles almost never land on these points. The stimulus table therefore places exact bit patterns there, including the tie just under 2^32, -0.3, -0.7, -0.5 and the smallest negative subnormal. Each pattern is paired with the modes that lead to different outcomes for it.

// File: rtl/dcvt_pkg.sv
package dcvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

endpackage

// File: rtl/dcvt_unpack.sv
module dcvt_unpack #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0]   fp_in,
  output logic                   sign,
  output logic                   special,
  output logic                   is_zero,
  output logic signed [EXP_W+1:0] exp_unb,
  output logic [MAN_W:0]         sig
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] frac_f;
  logic             exp_zero;

  always_comb begin
    sign     = fp_in[EXP_W+MAN_W];
    exp_f    = fp_in[EXP_W+MAN_W-1:MAN_W];
    frac_f   = fp_in[MAN_W-1:0];
    exp_zero = (exp_f == '0);
    special  = &exp_f;
    is_zero  = exp_zero && (frac_f == '0);
    exp_unb  = $signed({2'b00, exp_f}) - $signed((EXP_W+2)'(BIAS));
    sig      = {~exp_zero, frac_f};
  end
endmodule

// File: rtl/dcvt_align.sv
module dcvt_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic signed [EXP_W+1:0] exp_unb,
  input  logic [MAN_W:0]          sig,
  input  logic                    is_zero,
  output logic [INT_W-1:0]        int_part,
  output logic                    round_bit,
  output logic                    sticky_bit,
  output logic                    too_big
);
  localparam int EXT_W = MAN_W + INT_W;
  localparam int SH_W  = $clog2(INT_W);
  localparam logic signed [EXP_W+1:0] E_MINUS1 = -1;
  localparam logic signed [EXP_W+1:0] E_LIMIT  = (EXP_W+2)'(INT_W);

  logic [EXT_W-1:0] ext;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    shamt      = exp_unb[SH_W-1:0];
    ext        = {{(INT_W-1){1'b0}}, sig} << shamt;
    too_big    = (exp_unb >= E_LIMIT);
    int_part   = '0;
    round_bit  = 1'b0;
    sticky_bit = 1'b0;
    if (exp_unb < E_MINUS1) begin
      sticky_bit = ~is_zero;
    end else if (exp_unb == E_MINUS1) begin
      round_bit  = 1'b1;
      sticky_bit = |sig[MAN_W-1:0];
    end else if (!too_big) begin
      int_part   = ext[EXT_W-1:MAN_W];
      round_bit  = ext[MAN_W-1];
      sticky_bit = |ext[MAN_W-2:0];
    end
  end
endmodule

// File: rtl/dcvt_round.sv
module dcvt_round
  import dcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  rmode_e           rm,
  input  logic             sign,
  input  logic             special,
  input  logic             too_big,
  input  logic [INT_W-1:0] int_part,
  input  logic             round_bit,
  input  logic             sticky_bit,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx
);
  logic           lost;
  logic           away;
  logic           inc;
  logic [INT_W:0] mag;

  always_comb begin
    lost = round_bit | sticky_bit;
    unique case (rm)
      RM_NEAR: away = round_bit & (sticky_bit | int_part[0]);
      RM_DOWN: away = sign & lost;
      RM_UP:   away = ~sign & lost;
      default: away = 1'b0;
    endcase
    inc = away;
    mag = {1'b0, int_part} + {{INT_W{1'b0}}, inc};
    inv = special | too_big | (sign ? (mag != '0) : mag[INT_W]);
    inx = lost & ~inv;
    if (inv)       res = '1;
    else if (sign) res = '0;
    else           res = mag[INT_W-1:0];
  end

  always_comb begin
    assert_neg_zero_R6: assert (inv || !sign || res == '0)
      else $error("negative operand produced nonzero valid result");
  end
endmodule

// File: rtl/dcvt_u32.sv
module dcvt_u32
  import dcvt_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   operand,
  input  logic [1:0]             rm_global,
  input  logic [1:0]             rm_override,
  input  logic                   rm_sel,
  output logic                   out_valid,
  output logic [INT_W-1:0]       result,
  output logic                   invalid,
  output logic                   inexact
);
  localparam int FP_W = EXP_W + MAN_W + 1;

  rmode_e                  rm_eff;
  logic                    u_sign, u_special, u_zero;
  logic signed [EXP_W+1:0] u_exp;
  logic [MAN_W:0]          u_sig;
  logic [INT_W-1:0]        a_int;
  logic                    a_round, a_sticky, a_big;
  logic [INT_W-1:0]        c_res;
  logic                    c_inv, c_inx;

  logic [INT_W-1:0]        res_q, res_d;
  logic                    inv_q, inv_d, inx_q, inx_d, vld_q, vld_d;

  always_comb rm_eff = rmode_e'(rm_sel ? rm_override : rm_global);

  dcvt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .fp_in   (operand),
    .sign    (u_sign),
    .special (u_special),
    .is_zero (u_zero),
    .exp_unb (u_exp),
    .sig     (u_sig)
  );

  dcvt_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .exp_unb    (u_exp),
    .sig        (u_sig),
    .is_zero    (u_zero),
    .int_part   (a_int),
    .round_bit  (a_round),
    .sticky_bit (a_sticky),
    .too_big    (a_big)
  );

  dcvt_round #(.INT_W(INT_W)) u_round (
    .rm         (rm_eff),
    .sign       (u_sign),
    .special    (u_special),
    .too_big    (a_big),
    .int_part   (a_int),
    .round_bit  (a_round),
    .sticky_bit (a_sticky),
    .res        (c_res),
    .inv        (c_inv),
    .inx        (c_inx)
  );

  // next-state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    inv_d = inv_q;
    inx_d = inx_q;
    if (in_valid) begin
      res_d = c_res;
      inv_d = c_inv;
      inx_d = c_inx;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      inx_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      inv_q <= inv_d;
      inx_q <= inx_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign invalid   = inv_q;
  assign inexact   = inx_q;

  assert_invalid_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (result == '1));
  assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(invalid && inexact));
  assert_special_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&operand[FP_W-2:MAN_W])) |=> (invalid && !inexact));
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));
endmodule

// File: tb/sim_dcvt_u32.sv
module sim_dcvt_u32;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] operand;
  logic [1:0]  rm_global, rm_override;
  logic        rm_sel;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid, inexact;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dcvt_u32 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .rm_global(rm_global), .rm_override(rm_override), .rm_sel(rm_sel),
    .out_valid(out_valid), .result(result), .invalid(invalid), .inexact(inexact)
  );

  // {operand, mode, expected result, expected invalid, expected inexact}
  localparam int NV = 30;
  localparam logic [99:0] VEC [NV] = '{
    {64'h3FF0000000000000, 2'b00, 32'd1,          1'b0, 1'b0}, // R2 1.0
    {64'h41CDCD6500000000, 2'b01, 32'd1000000000, 1'b0, 1'b0}, // R2 1e9
    {64'h41EFFFFFFFE00000, 2'b10, 32'hFFFFFFFF,   1'b0, 1'b0}, // R2 max exact
    {64'h3FF8000000000000, 2'b00, 32'd2,          1'b0, 1'b1}, // R3 1.5 RNE
    {64'h4004000000000000, 2'b00, 32'd2,          1'b0, 1'b1}, // R2 2.5 tie even
    {64'h4004000000000000, 2'b01, 32'd2,          1'b0, 1'b1}, // R2
    {64'h4004000000000000, 2'b10, 32'd3,          1'b0, 1'b1}, // R2
    {64'h4004000000000000, 2'b11, 32'd2,          1'b0, 1'b1}, // R2
    {64'h400E000000000000, 2'b00, 32'd4,          1'b0, 1'b1}, // R3 3.75
    {64'h400E000000000000, 2'b11, 32'd3,          1'b0, 1'b1}, // R3
    {64'h3FE0000000000000, 2'b00, 32'd0,          1'b0, 1'b1}, // R3 0.5 tie
    {64'h3FE0000000000000, 2'b10, 32'd1,          1'b0, 1'b1}, // R3
    {64'h41EFFFFFFFF00000, 2'b00, 32'hFFFFFFFF,   1'b1, 1'b0}, // R4 2^32-0.5
    {64'h41EFFFFFFFF00000, 2'b11, 32'hFFFFFFFF,   1'b0, 1'b1}, // R4
    {64'h41F0000000000000, 2'b11, 32'hFFFFFFFF,   1'b1, 1'b0}, // R4 2^32
    {64'h4415AF1D78B58C40, 2'b00, 32'hFFFFFFFF,   1'b1, 1'b0}, // R4 1e20
    {64'h7FF0000000000000, 2'b00, 32'hFFFFFFFF,   1'b1, 1'b0}, // R5 +inf
    {64'hFFF0000000000000, 2'b11, 32'hFFFFFFFF,   1'b1, 1'b0}, // R5 -inf
    {64'h7FF8000000000000, 2'b10, 32'hFFFFFFFF,   1'b1, 1'b0}, // R5 NaN
    {64'h8000000000000000, 2'b01, 32'd0,          1'b0, 1'b0}, // R6 -0
    {64'hBFD3333333333333, 2'b11, 32'd0,          1'b0, 1'b1}, // R6 -0.3
    {64'hBFD3333333333333, 2'b00, 32'd0,          1'b0, 1'b1}, // R6
    {64'hBFE0000000000000, 2'b00, 32'd0,          1'b0, 1'b1}, // R6 -0.5
    {64'hBFD3333333333333, 2'b01, 32'hFFFFFFFF,   1'b1, 1'b0}, // R7 R8
    {64'hBFE6666666666666, 2'b00, 32'hFFFFFFFF,   1'b1, 1'b0}, // R7 -0.7
    {64'hBFF0000000000000, 2'b11, 32'hFFFFFFFF,   1'b1, 1'b0}, // R7 -1.0
    {64'h8000000000000001, 2'b01, 32'hFFFFFFFF,   1'b1, 1'b0}, // R7 R11
    {64'h0000000000000001, 2'b00, 32'd0,          1'b0, 1'b1}, // R11
    {64'h0000000000000001, 2'b10, 32'd1,          1'b0, 1'b1}, // R11
    {64'h000FFFFFFFFFFFFF, 2'b01, 32'd0,          1'b0, 1'b1}  // R11
  };

  task automatic chk(input string tag, input logic [31:0] er,
                     input logic ei, input logic ex, input logic ev);
    n_chk++;
    if (result !== er || invalid !== ei || inexact !== ex || out_valid !== ev) begin
      n_bad++;
      $display("FAIL %s: got res=%h inv=%b inx=%b vld=%b exp res=%h inv=%b inx=%b vld=%b",
               tag, result, invalid, inexact, out_valid, er, ei, ex, ev);
    end
  endtask

  task automatic apply(input logic [63:0] op, input logic [1:0] m);
    @(negedge clk);
    operand     = op;
    rm_override = m;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid    = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0;
    rm_global = 2'b11; rm_override = 2'b00; rm_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset", 32'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:36], VEC[i][35:34]);
      chk($sformatf("vec%0d R2-table", i), VEC[i][33:2], VEC[i][1], VEC[i][0], 1'b1);
    end

    // R9: hold while in_valid low
    apply(64'h4004000000000000, 2'b10);
    operand = 64'h7FF0000000000000;
    @(negedge clk);
    chk("R9 hold", 32'd3, 1'b0, 1'b1, 1'b0);

    // R1: global vs override
    rm_sel = 1'b0; rm_global = 2'b11;
    apply(64'h4004000000000000, 2'b10);
    chk("R1 global", 32'd2, 1'b0, 1'b1, 1'b1);
    rm_sel = 1'b1;
    apply(64'h4004000000000000, 2'b10);
    chk("R1 override", 32'd3, 1'b0, 1'b1, 1'b1);
    rm_sel = 1'b0; rm_global = 2'b00;
    apply(64'h41EFFFFFFFF00000, 2'b11);
    chk("R1 R4 global nearest", 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1);

    // R9: back-to-back
    rm_sel = 1'b1;
    @(negedge clk);
    operand = 64'h3FF0000000000000; rm_override = 2'b00; in_valid = 1'b1;
    @(negedge clk);
    chk("R9 b2b first", 32'd1, 1'b0, 1'b0, 1'b1);
    operand = 64'h400E000000000000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 b2b second", 32'd4, 1'b0, 1'b1, 1'b1);

    // R10: reset in mid-run
    rst_n = 1'b0;
    #2;
    chk("R10 async clear", 32'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule